// File: doc/BRIEF.md
# Multichannel SAR scan sequencer

This block is the digital control for an eight-channel successive-approximation converter that loops forever. It picks the analog channel through a 3-bit mux select, drives the code under trial to an external DAC, and reads back one comparator bit that is high when the DAC level is above the selected input. Every channel gets a fixed 80-clock frame. A frame holds a settling window, eight trial slots of eight clocks each with the most significant bit first, and a tail. In the tail the finished code is handed to a result memory as a single-cycle write.

Channels are visited in decreasing order and wrap from 0 back to 7. An active-low status line falls on the same edge that moves the mux select. It stays low for 8 clocks after a normal channel completes. In the frame that converts channel 0 it stays low for 72 clocks, so a simple pulse-width detector can tell which channel is active. After reset, a start-up count holds the block idle before the first frame.

Top module: `sar_scan_seq`

## Requirements
- R1: While `rst_n` is low, `mux_sel` is 7, `stat_n` is 1, `dac_code` is 0 and `res_we` is 0.
- R2: In frame offsets 8 to 71, trial slot j (offsets 8+8j to 15+8j) drives `dac_code` with the already decided upper bits, bit 7-j set to 1 and all lower bits 0. The trial bit is cleared when `cmp_gt` is 1 at the slot's last clock and kept otherwise. In offsets 72 to 79 `dac_code` holds the final code. In offsets 0 to 7 it is 0.
- R3: `res_we` is high for exactly one clock, at frame offset 74. In that clock `res_addr` equals the channel converted in the frame and `res_data` equals the final code. This is 6 clocks before the next frame, when `stat_n` falls.
- R4: For a frame on channels 1 to 7 that follows a completed conversion, `stat_n` is 0 at offsets 0 to 7 and 1 for the rest of the frame.
- R5: In the frame on channel 0, `stat_n` is 0 at offsets 0 to 71 and 1 at offsets 72 to 79.
- R6: `mux_sel` changes only at the edge that starts a new frame, where it moves to the next lower channel and wraps from 0 to 7. This is the same edge at which `stat_n` falls.
- R7: Every frame lasts exactly 80 clocks, so consecutive writes are 80 clocks apart and a full scan takes 640 clocks.
- R8: After reset release the block stays idle for 80 clocks (`mux_sel` 7, `dac_code` 0, `stat_n` 1, no write). It then runs a first frame on channel 7 with `stat_n` held high. The first write comes 154 clocks after release, well inside 800.
- R9: With an ideal comparator, the code written for a channel equals that channel's input level, for all codes including 0x00, 0xFF and values near mid-scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| cmp_gt | input | 1 | Comparator: 1 when DAC level exceeds the selected input |
| mux_sel | output | 3 | Analog channel select |
| dac_code | output | 8 | Code under trial, driven to the DAC |
| res_we | output | 1 | Result memory write strobe, one clock |
| res_addr | output | 3 | Result memory slot (channel) |
| res_data | output | 8 | Converted code |
| stat_n | output | 1 | Active-low status pulse; 8 clocks normally, 72 for channel 0 |

## Verification
Every output follows from the number of rising edges since reset release. The first 80 are idle. After that, the frame offset is (edges-80) mod 80 and the frame number picks the channel 7 minus frame mod 8. The trial code for a slot appears at offset 8+8j, one edge after the previous decision is sampled. The write is due at offset 74 and the status edges at offsets 0, 8 and 72. The bench recomputes all of this in every cycle and compares at the falling edge. It feeds the comparator from a per-scan table of input levels, so each channel's result is due at its own offset-74 cycle.

// File: rtl/sar_scan_pkg.sv
package sar_scan_pkg;
  typedef enum logic [1:0] {
    PH_START  = 2'd0,
    PH_SETTLE = 2'd1,
    PH_TRIAL  = 2'd2,
    PH_TAIL   = 2'd3
  } scan_phase_t;
endpackage

// File: rtl/sar_scan_timer.sv
module sar_scan_timer
  import sar_scan_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int SETTLE    = 8,
  parameter int TRIAL     = 8,
  parameter int TAIL      = 8,
  parameter int START_CYC = 80,
  localparam int FRAME    = SETTLE + CODE_W * TRIAL + TAIL,
  localparam int CW       = $clog2(FRAME),
  localparam int IW       = $clog2(CODE_W),
  localparam int SW       = $clog2(START_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output scan_phase_t   phase,
  output logic          trial_load,
  output logic          bit_done,
  output logic [IW-1:0] bit_idx,
  output logic          frame_end
);
  localparam int TRIAL_END = SETTLE + CODE_W * TRIAL;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] st_q, st_d;
  logic          run_q, run_d;
  int            off;

  always_comb begin
    cnt_d = cnt_q;
    st_d  = st_q;
    run_d = run_q;
    if (!run_q) begin
      if (st_q == SW'(START_CYC - 1)) run_d = 1'b1;
      else                            st_d  = st_q + SW'(1);
    end else if (cnt_q == CW'(FRAME - 1)) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      st_q  <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      st_q  <= st_d;
      run_q <= run_d;
    end
  end

  always_comb begin
    off        = int'(cnt_q) - SETTLE;
    trial_load = run_q && (cnt_q == CW'(SETTLE - 1));
    frame_end  = run_q && (cnt_q == CW'(FRAME - 1));
    bit_done   = 1'b0;
    bit_idx    = '0;
    if (off >= 0 && off < CODE_W * TRIAL) begin
      bit_idx  = IW'(CODE_W - 1 - off / TRIAL);
      bit_done = run_q && ((off % TRIAL) == TRIAL - 1);
    end
    if (!run_q)                         phase = PH_START;
    else if (int'(cnt_q) < SETTLE)      phase = PH_SETTLE;
    else if (int'(cnt_q) < TRIAL_END)   phase = PH_TRIAL;
    else                                phase = PH_TAIL;
  end

  assign cnt = cnt_q;

  assert_frame_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < FRAME);
  assert_run_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);
  assert_idle_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> cnt_q == '0);
endmodule

// File: rtl/sar_scan_reg.sv
module sar_scan_reg #(
  parameter int CODE_W = 8,
  localparam int IW    = $clog2(CODE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trial_load,
  input  logic              bit_done,
  input  logic [IW-1:0]     bit_idx,
  input  logic              cmp_gt,
  input  logic              frame_end,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;

  always_comb begin
    code_d  = code_q;
    code_en = frame_end | trial_load | bit_done;
    if (frame_end) begin
      code_d = '0;
    end else if (trial_load) begin
      code_d = '0;
      code_d[CODE_W-1] = 1'b1;
    end else if (bit_done) begin
      if (cmp_gt) code_d[bit_idx] = 1'b0;
      if (bit_idx != '0) code_d[bit_idx - IW'(1)] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  assign code = code_q;

  assert_keep_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_done && !cmp_gt) |=> code_q[$past(bit_idx)]);
  assert_drop_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_done && cmp_gt) |=> !code_q[$past(bit_idx)]);
  assert_msb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trial_load |=> $countones(code_q) == 1 && code_q[CODE_W-1]);
endmodule

// File: rtl/sar_scan_out.sv
module sar_scan_out #(
  parameter int NCH       = 8,
  parameter int CODE_W    = 8,
  parameter int CW        = 7,
  parameter int STAT_LEN  = 8,
  parameter int LONG_LEN  = 72,
  parameter int WR_STROBE = 73,
  localparam int AW       = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CW-1:0]     cnt,
  input  logic              frame_end,
  input  logic [CODE_W-1:0] code,
  output logic [AW-1:0]     chan,
  output logic              stat_n,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output logic [CODE_W-1:0] wdata
);
  logic [AW-1:0]     chan_q, chan_d;
  logic              stat_q, stat_d;
  logic              we_q, we_d;
  logic [AW-1:0]     waddr_q;
  logic [CODE_W-1:0] wdata_q;

  always_comb begin
    chan_d = (chan_q == '0) ? AW'(NCH - 1) : chan_q - AW'(1);
    stat_d = stat_q;
    if (frame_end)
      stat_d = 1'b0;
    else if (chan_q != '0 && cnt == CW'(STAT_LEN - 1))
      stat_d = 1'b1;
    else if (cnt == CW'(LONG_LEN - 1))
      stat_d = 1'b1;
    we_d = run && (cnt == CW'(WR_STROBE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q  <= AW'(NCH - 1);
      stat_q  <= 1'b1;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      if (frame_end) chan_q <= chan_d;
      stat_q <= stat_d;
      we_q   <= we_d;
      if (we_d) begin
        waddr_q <= chan_q;
        wdata_q <= code;
      end
    end
  end

  assign chan   = chan_q;
  assign stat_n = stat_q;
  assign we     = we_q;
  assign waddr  = waddr_q;
  assign wdata  = wdata_q;

  assert_we_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);
  assert_stat_with_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q) |-> chan_q != $past(chan_q));
  assert_short_stat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && chan_q != '0 && cnt == CW'(STAT_LEN)) |-> stat_q);
  assert_long_stat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_q == '0 && cnt == CW'(STAT_LEN)) |-> !stat_q);
endmodule

// File: rtl/sar_scan_seq.sv
module sar_scan_seq
  import sar_scan_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int CODE_W    = 8,
  parameter int SETTLE    = 8,
  parameter int TRIAL     = 8,
  parameter int TAIL      = 8,
  parameter int STAT_LEN  = 8,
  parameter int WR_LEAD   = 6,
  parameter int START_CYC = 80,
  localparam int AW       = $clog2(NCH),
  localparam int FRAME    = SETTLE + CODE_W * TRIAL + TAIL,
  localparam int LONG_LEN = SETTLE + CODE_W * TRIAL,
  localparam int CW       = $clog2(FRAME),
  localparam int IW       = $clog2(CODE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_gt,
  output logic [AW-1:0]     mux_sel,
  output logic [CODE_W-1:0] dac_code,
  output logic              res_we,
  output logic [AW-1:0]     res_addr,
  output logic [CODE_W-1:0] res_data,
  output logic              stat_n
);
  logic [CW-1:0] cnt;
  scan_phase_t   phase;
  logic          trial_load, bit_done, frame_end, run;
  logic [IW-1:0] bit_idx;

  sar_scan_timer #(
    .CODE_W(CODE_W), .SETTLE(SETTLE), .TRIAL(TRIAL),
    .TAIL(TAIL), .START_CYC(START_CYC)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .phase(phase),
    .trial_load(trial_load), .bit_done(bit_done),
    .bit_idx(bit_idx), .frame_end(frame_end)
  );

  assign run = (phase != PH_START);

  sar_scan_reg #(.CODE_W(CODE_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .trial_load(trial_load),
    .bit_done(bit_done), .bit_idx(bit_idx), .cmp_gt(cmp_gt),
    .frame_end(frame_end), .code(dac_code)
  );

  sar_scan_out #(
    .NCH(NCH), .CODE_W(CODE_W), .CW(CW), .STAT_LEN(STAT_LEN),
    .LONG_LEN(LONG_LEN), .WR_STROBE(FRAME - WR_LEAD - 1)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt),
    .frame_end(frame_end), .code(dac_code), .chan(mux_sel),
    .stat_n(stat_n), .we(res_we), .waddr(res_addr), .wdata(res_data)
  );

  assert_write_in_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> $past(phase) == PH_TAIL);
endmodule

// File: tb/sar_scan_seq_bench.sv
`timescale 1ns/1ps
module sar_scan_seq_bench;
  localparam int S     = 80;
  localparam int FRAME = 80;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_gt;
  logic [2:0] mux_sel;
  logic [7:0] dac_code;
  logic       res_we;
  logic [2:0] res_addr;
  logic [7:0] res_data;
  logic       stat_n;
  logic [7:0] vin_now = 8'd0;

  int checks = 0;
  int errors = 0;
  int k = 0;
  int last_we = -1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign cmp_gt = dac_code > vin_now;

  sar_scan_seq u_sar_scan_seq (
    .clk(clk), .rst_n(rst_n), .cmp_gt(cmp_gt), .mux_sel(mux_sel),
    .dac_code(dac_code), .res_we(res_we), .res_addr(res_addr),
    .res_data(res_data), .stat_n(stat_n)
  );

  function automatic logic [7:0] pat(int s, int ch);
    case (s % 6)
      0: return 8'(ch * 37 + 3);
      1: return 8'hFF;
      2: return 8'h00;
      3: return 8'(8'h80 ^ ch);
      4: return 8'(127 - ch);
      default: return 8'(s * 53 + ch * 91);
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, k, act, exp);
    end
  endtask

  task automatic check_cycle();
    int c, f, ch, s, v, j, e_dac, e_stat;
    if (k < S) begin
      check(mux_sel == 3'd7, "R8 mux idle", mux_sel, 7);
      check(stat_n == 1'b1, "R8 stat idle", stat_n, 1);
      check(dac_code == 8'd0, "R8 dac idle", dac_code, 0);
      check(res_we == 1'b0, "R8 no write idle", res_we, 0);
      return;
    end
    c  = (k - S) % FRAME;
    f  = (k - S) / FRAME;
    ch = 7 - (f % 8);
    s  = f / 8;
    v  = int'(pat(s, ch));
    check(mux_sel == 3'(ch), "R6 channel order", mux_sel, ch);
    e_stat = (f >= 1 && (c < 8 || (ch == 0 && c < 72))) ? 0 : 1;
    if (f == 0)       check(stat_n == 1'(e_stat), "R8 first frame stat", stat_n, e_stat);
    else if (ch == 0) check(stat_n == 1'(e_stat), "R5 long stat", stat_n, e_stat);
    else              check(stat_n == 1'(e_stat), "R4 short stat", stat_n, e_stat);
    if (c < 8) e_dac = 0;
    else if (c < 72) begin
      j = (c - 8) / 8;
      e_dac = ((v >> (8 - j)) << (8 - j)) | (1 << (7 - j));
    end else e_dac = v;
    check(dac_code == 8'(e_dac), "R2 trial code", dac_code, e_dac);
    check(res_we == (c == 74), "R3 write timing", res_we, (c == 74) ? 1 : 0);
    if (res_we && c == 74) begin
      check(res_addr == 3'(ch), "R3 write address", res_addr, ch);
      check(res_data == 8'(v), "R9 result value", res_data, v);
      if (last_we >= 0) check(k - last_we == FRAME, "R7 frame length", k - last_we, FRAME);
      else              check(k == 154, "R8 first write", k, 154);
      last_we = k;
    end
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      k++;
      check_cycle();
      if (k >= S) vin_now = pat(((k - S) / FRAME) / 8, int'(mux_sel));
      else        vin_now = 8'd0;
    end
  endtask

  task automatic check_reset();
    check(mux_sel == 3'd7, "R1 reset mux", mux_sel, 7);
    check(stat_n == 1'b1, "R1 reset stat", stat_n, 1);
    check(dac_code == 8'd0, "R1 reset dac", dac_code, 0);
    check(res_we == 1'b0, "R1 reset write", res_we, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    k = 0;
    run_cycles(S + FRAME * 8 * 7);
    // mid-frame reset, then a fresh start-up and one full scan plus a frame
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    k = 0;
    last_we = -1;
    run_cycles(S + FRAME * 9 + 5);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at edge %0d", k);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule